// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable counter built from 4-bit digits that counts either up or down. Every register updates on the rising clock edge. A synchronous parallel load, a shared active-high synchronous reset and two active-low count enables control it. The parallel enable holds or releases every digit. The trickle enable feeds the lowest digit. Each digit's active-low ripple carry becomes the trickle enable of the digit above it, so the chain forms one wide counter without extra gating.

A parameter sets the number of digits. A second parameter sets the range of each digit: binary (0 to 15) or decade (0 to 9). Direction, enables and load may change at any point in the clock period. They take effect only at the next rising edge.

Top module: `cascade_updown_counter`

## Requirements
- R1: When `rst` is high at a rising edge, every digit of `q` becomes 0.
- R2: When `load_n` is low at a rising edge, `q` takes the value of `din` on that edge. This holds whatever the levels of `up`, `en_par_n` and `en_trk_n`, because load has priority over counting.
- R3: When `load_n` is high and either `en_par_n` or `en_trk_n` is high at an edge, `q` keeps its value.
- R4: Counting happens when `load_n` is high and both enables are low. With `up` high, the lowest digit increments by one. With `up` low, it decrements by one.
- R5: A digit wraps around. Counting up from its maximum gives 0, and counting down from 0 gives its maximum. The maximum is 15 per digit in binary mode (`DECADE`=0) and 9 per digit in decade mode (`DECADE`=1).
- R6: `carry_n` is combinational and goes low only when `en_trk_n` is low and every digit is at its terminal value. The terminal value is the maximum when `up` is high and 0 when `up` is low. `en_par_n` has no effect on `carry_n`.
- R7: Digit k, counting from 0 at the least significant end of `q`, moves only when every lower digit is at its terminal value. In binary mode the whole `q` therefore steps by ±1 modulo 2^(4·STAGES). In decade mode it steps as a BCD number.
- R8: In decade mode, a digit loaded with a value from 10 to 15 steps by a plain 4-bit increment or decrement (for example 12→13 up, 12→11 down, 15→0 up). Such a digit is never terminal when counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load, active low |
| din | input | 4·STAGES | Preset value, digit 0 in bits 3:0 |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| en_par_n | input | 1 | Parallel count enable, active low, shared by all digits |
| en_trk_n | input | 1 | Trickle count enable, active low, feeds digit 0 and the carry chain |
| q | output | 4·STAGES | Count value, digit 0 in bits 3:0 |
| carry_n | output | 1 | Ripple carry of the top digit, active low |

## Verification
The hardest state to reach from the ports is a carry that runs through the whole chain. This needs every digit at its terminal value together. In decade mode it also needs all digits inside 0 to 9 after a load of out-of-range values. Free counting from reset would take up to 2^(4·STAGES) steps to get there. Instead, the stimulus presets the chain just below or at the terminal pattern (all-ones, all-nines, all-zeros) and then counts across it in both directions. Random loads that often include digits above 9 are mixed in. A binary instance and a decade instance share the same inputs, so one input sequence checks both ranges.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } op_e;

    typedef struct packed {
        logic load_n;
        logic up;
        logic enp_n;
        logic ent_n;
    } ctrl_t;

    // Largest value a digit reaches before wrapping
    function automatic digit_t digit_max(input bit decade);
        return decade ? digit_t'(9) : digit_t'(15);
    endfunction

    // Terminal value depends on direction
    function automatic logic at_terminal(input digit_t v, input logic up, input digit_t mx);
        return up ? (v == mx) : (v == '0);
    endfunction

    // Next value of one digit for a decoded operation
    function automatic digit_t step_digit(input digit_t v, input op_e op,
                                          input digit_t mx, input digit_t d);
        digit_t r;
        case (op)
            OP_LOAD: r = d;
            OP_INC:  r = (v == mx) ? '0 : v + digit_t'(1);
            OP_DEC:  r = (v == '0) ? mx : v - digit_t'(1);
            default: r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/updn_op_decode.sv
module updn_op_decode
    import updn_pkg::*;
(
    input  ctrl_t ctrl,
    output op_e   op
);
    always_comb begin
        if (!ctrl.load_n)
            op = OP_LOAD;
        else if (!ctrl.enp_n && !ctrl.ent_n)
            op = ctrl.up ? OP_INC : OP_DEC;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/updn_digit.sv
module updn_digit
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  ctrl_t  ctrl,
    input  digit_t d,
    output digit_t q,
    output logic   rco_n
);
    localparam digit_t MAXV = digit_max(DECADE);

    op_e    op;
    digit_t q_r;
    digit_t q_nx;

    updn_op_decode u_dec (
        .ctrl (ctrl),
        .op   (op)
    );

    always_comb q_nx = step_digit(q_r, op, MAXV, d);

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nx;
    end

    assign q     = q_r;
    assign rco_n = !(!ctrl.ent_n && at_terminal(q_r, ctrl.up, MAXV));
endmodule

// File: rtl/cascade_updown_counter.sv
module cascade_updown_counter
    import updn_pkg::*;
#(
    parameter int STAGES = 2,
    parameter bit DECADE = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_n,
    input  logic [STAGES*DIGIT_W-1:0] din,
    input  logic                      up,
    input  logic                      en_par_n,
    input  logic                      en_trk_n,
    output logic [STAGES*DIGIT_W-1:0] q,
    output logic                      carry_n
);
    // Trickle enable entering each digit; the last entry is the chain carry
    logic [STAGES:0] ent_chain;

    assign ent_chain[0] = en_trk_n;

    for (genvar g = 0; g < STAGES; g++) begin : g_digit
        ctrl_t  st_ctrl;
        digit_t st_q;

        assign st_ctrl = '{load_n: load_n, up: up, enp_n: en_par_n, ent_n: ent_chain[g]};

        updn_digit #(.DECADE(DECADE)) u_digit (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (st_ctrl),
            .d     (din[g*DIGIT_W +: DIGIT_W]),
            .q     (st_q),
            .rco_n (ent_chain[g+1])
        );

        assign q[g*DIGIT_W +: DIGIT_W] = st_q;
    end

    assign carry_n = ent_chain[STAGES];
endmodule

// File: rtl/updn_chk.sv
module updn_chk
    import updn_pkg::*;
#(
    parameter int STAGES = 2,
    parameter bit DECADE = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      load_n,
    input logic [STAGES*DIGIT_W-1:0] din,
    input logic                      up,
    input logic                      en_par_n,
    input logic                      en_trk_n,
    input logic [STAGES*DIGIT_W-1:0] q,
    input logic                      carry_n
);
    localparam int W = STAGES*DIGIT_W;
    localparam logic [W-1:0] TOP_VAL = {STAGES{digit_max(DECADE)}};

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> q == '0); // R1

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> q == $past(din)); // R2

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (load_n && (en_par_n || en_trk_n)) |=> $stable(q)); // R3

    AST_CARRY_NEEDS_TRICKLE: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> !en_trk_n); // R6

    AST_CARRY_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> (up ? (q == TOP_VAL) : (q == '0))); // R6

    if (!DECADE) begin : g_bin
        AST_BIN_STEP_UP: assert property (@(posedge clk) disable iff (rst)
            (load_n && !en_par_n && !en_trk_n && up) |=> q == $past(q) + W'(1)); // R7

        AST_BIN_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
            (load_n && !en_par_n && !en_trk_n && !up) |=> q == $past(q) - W'(1)); // R4
    end
endmodule

bind cascade_updown_counter updn_chk #(.STAGES(STAGES), .DECADE(DECADE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .din      (din),
    .up       (up),
    .en_par_n (en_par_n),
    .en_trk_n (en_trk_n),
    .q        (q),
    .carry_n  (carry_n)
);

// File: tb/cascade_updown_counter_test.sv
`timescale 1ns/1ps
module cascade_updown_counter_test;
    localparam int NS = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_n = 1'b1;
    logic [7:0] din = '0;
    logic       up = 1'b1;
    logic       en_par_n = 1'b1;
    logic       en_trk_n = 1'b1;
    logic [7:0] q_bin, q_dec;
    logic       carry_bin, carry_dec;

    int total = 0;
    int fails = 0;
    logic [7:0] mb = '0;
    logic [7:0] md = '0;

    always #4 clk = ~clk;

    cascade_updown_counter #(.STAGES(NS), .DECADE(1'b0)) uut (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din), .up(up),
        .en_par_n(en_par_n), .en_trk_n(en_trk_n), .q(q_bin), .carry_n(carry_bin));

    cascade_updown_counter #(.STAGES(NS), .DECADE(1'b1)) uut_dec (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din), .up(up),
        .en_par_n(en_par_n), .en_trk_n(en_trk_n), .q(q_dec), .carry_n(carry_dec));

    function automatic logic [3:0] dnext(input logic [3:0] v, input logic u, input logic [3:0] mx);
        if (u) return (v == mx) ? 4'd0 : v + 4'd1;
        return (v == 4'd0) ? mx : v - 4'd1;
    endfunction

    function automatic logic term(input logic [3:0] v, input logic u, input logic [3:0] mx);
        return u ? (v == mx) : (v == 4'd0);
    endfunction

    function automatic logic [7:0] model_next(input logic [7:0] s, input logic [3:0] mx,
            input logic ld, input logic [7:0] d, input logic u, input logic p, input logic t);
        logic [7:0] r = s;
        logic e = t;
        for (int i = 0; i < NS; i++) begin
            logic [3:0] v;
            v = s[i*4 +: 4];
            if (!ld) r[i*4 +: 4] = d[i*4 +: 4];
            else if (!p && !e) r[i*4 +: 4] = dnext(v, u, mx);
            e = !(!e && term(v, u, mx));
        end
        return r;
    endfunction

    function automatic logic model_carry(input logic [7:0] s, input logic [3:0] mx,
            input logic u, input logic t);
        logic e = t;
        for (int i = 0; i < NS; i++) e = !(!e && term(s[i*4 +: 4], u, mx));
        return e;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge
    task automatic step(input string tag, input logic ld, input logic [7:0] d,
                        input logic u, input logic p, input logic t);
        logic [7:0] nb, nd;
        load_n = ld; din = d; up = u; en_par_n = p; en_trk_n = t;
        #1;
        chk("R6 binary carry", {7'd0, carry_bin}, {7'd0, model_carry(mb, 4'd15, u, t)});
        chk("R6 decade carry", {7'd0, carry_dec}, {7'd0, model_carry(md, 4'd9, u, t)});
        nb = model_next(mb, 4'd15, ld, d, u, p, t);
        nd = model_next(md, 4'd9, ld, d, u, p, t);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " binary"}, q_bin, nb);
        chk({tag, " decade"}, q_dec, nd);
        if (ld && !p && !t)
            chk("R7 binary arithmetic", q_bin, u ? mb + 8'd1 : mb - 8'd1);
        mb = nb;
        md = nd;
    endtask

    initial begin
        #(8 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset binary", q_bin, 8'h00);
        chk("R1 reset decade", q_dec, 8'h00);
        rst = 1'b0;

        step("R2 load enables off", 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1);
        step("R2 load beats count", 1'b0, 8'h57, 1'b0, 1'b0, 1'b0);
        step("R3 parallel off",     1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        step("R3 trickle off",      1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
        step("R4 up",               1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step("R4 down",             1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        // Full-chain terminal, up
        step("R2 preset 99",        1'b0, 8'h99, 1'b1, 1'b1, 1'b1);
        step("R6 enp blocks only count", 1'b1, 8'h00, 1'b1, 1'b1, 1'b0);
        step("R5 wrap up decade",   1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step("R2 preset FF",        1'b0, 8'hFF, 1'b1, 1'b1, 1'b1);
        step("R5 R8 wrap up all ones", 1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        // Full-chain terminal, down
        step("R5 wrap down zero",   1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        step("R7 borrow",           1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        step("R2 preset 10",        1'b0, 8'h10, 1'b0, 1'b1, 1'b1);
        step("R7 borrow into upper",1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        // Out-of-range decade digits
        step("R2 preset CC",        1'b0, 8'hCC, 1'b1, 1'b1, 1'b1);
        step("R8 up from 12",       1'b1, 8'h00, 1'b1, 1'b0, 1'b0);
        step("R8 down",             1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        step("R8 down again",       1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
        // Reset mid-run
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 reset mid-run binary", q_bin, 8'h00);
        chk("R1 reset mid-run decade", q_dec, 8'h00);
        rst = 1'b0;
        mb = '0;
        md = '0;

        for (int n = 0; n < 400; n++) begin
            logic ld, u, p, t;
            logic [7:0] d;
            ld = ($urandom % 8) != 0;
            u  = $urandom % 2;
            p  = ($urandom % 5) == 0;
            t  = ($urandom % 5) == 0;
            case ($urandom % 4)
                0: d = 8'h99;
                1: d = 8'hFF;
                2: d = {4'($urandom % 10), 4'($urandom % 10)};
                default: d = 8'($urandom);
            endcase
            step("R3 R4 random", ld, d, u, p, t);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule